// File: doc/BRIEF.md
# Variable-Length Bytecode Instruction Decoder

This block turns a window of raw instruction bytes into decoded fields for a small processor whose registers are named by single-assignment (SSA) identifiers. The window holds up to nine bytes. Its lowest byte is the byte at the current program counter. Byte 0 is an opcode and byte 1 is the total instruction length, counting both of those bytes. The remaining operands sit at byte positions that depend on the opcode.

The decoder reports:
- an operation class and the instruction length;
- up to three SSA identifiers;
- a 32-bit constant;
- two absolute 16-bit branch targets;
- two predecessor-edge tags, which later steps use to select the correct input of a merge (phi) instruction.

An unknown opcode, or a length byte that disagrees with its opcode, is reported as illegal with a length of 2. This lets the fetch logic still advance.

Windows enter through a valid/ready handshake and results leave through another. A window is taken when `in_valid` and `in_ready` are both high on a clock edge. A result is taken when `out_valid` and `out_ready` are both high. With the default registered output, the decoder holds one result. While that result is not taken, it stays on the outputs unchanged and `in_ready` is low. The fetch side must hold its window and `in_valid` until the window is accepted. With `REG_OUT` = 0 the block is purely combinational: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`.

Top module: `bcd_decoder`

## Requirements
- R1: The legal pairs of opcode and length byte are listed below. A legal pair gives `out_illegal`=0, the class code shown, and `out_len` equal to the length byte.

  | Opcode | Length | Class |
  |---|---|---|
  | 0x01 | 7 | 1 |
  | 0x02 | 5 | 2 |
  | 0x03 | 5 | 3 |
  | 0x04 | 5 | 4 |
  | 0x05 | 4 | 5 |
  | 0x06 | 4 | 6 |
  | 0x07 | 9 | 7 |
  | 0x08 | 5 | 8 |
  | 0x09 | 3 | 9 |
  | 0x0A | 7 | 10 |
  | 0xFF | 2 | 11 |

  The class codes name the operations: 1 constant, 2 add, 3 subtract, 4 multiply, 5 load, 6 store, 7 conditional branch, 8 jump, 9 return, 10 phi, 11 halt.
- R2: Any other opcode, or a listed opcode with a different length byte, gives `out_illegal`=1, class 0, `out_len`=2 and every field zero.
- R3: Constant (class 1): `out_dest` is byte 2. `out_imm` is {byte6, byte5, byte4, byte3}, so byte 3 is least significant.
- R4: Add, subtract and multiply (classes 2–4): `out_dest` is byte 2, `out_src_a` is byte 3 and `out_src_b` is byte 4.
- R5: Load (class 5): `out_dest` is byte 2 and `out_src_a` (the address) is byte 3. Store (class 6): `out_src_a` (the data) is byte 2 and `out_src_b` (the address) is byte 3.
- R6: Conditional branch (class 7): `out_src_a` (the condition) is byte 2. `out_tgt_t` is {byte4, byte3} and `out_tgt_f` is {byte6, byte5}. `out_tag_t` is byte 7 and `out_tag_f` is byte 8.
- R7: Jump (class 8): `out_tgt_t` is {byte3, byte2} and `out_tag_t` is byte 4. Return (class 9): `out_src_a` is byte 2.
- R8: Phi (class 10): `out_dest` is byte 2, `out_src_a` is byte 3 and `out_src_b` is byte 4. The tag paired with source A, `out_tag_t`, is byte 5. The tag paired with source B, `out_tag_f`, is byte 6.
- R9: Every output field that the decoded class does not use is zero. For halt, all fields are zero.
- R10: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold their values. Each accepted window yields exactly one result, in the order the windows were accepted.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window valid |
| in_ready | output | 1 | Decoder can take a window |
| in_window | input | 72 | Instruction bytes; byte k in bits [8k+7:8k] |
| out_valid | output | 1 | Decoded result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_class | output | 4 | Operation class code |
| out_len | output | 4 | Instruction length in bytes |
| out_illegal | output | 1 | Unknown opcode or length mismatch |
| out_dest | output | 8 | Destination SSA identifier |
| out_src_a | output | 8 | First source SSA identifier |
| out_src_b | output | 8 | Second source SSA identifier |
| out_imm | output | 32 | Constant value |
| out_tgt_t | output | 16 | Taken / jump target address |
| out_tgt_f | output | 16 | Not-taken target address |
| out_tag_t | output | 8 | Predecessor tag for taken edge / source A |
| out_tag_f | output | 8 | Predecessor tag for not-taken edge / source B |

## Verification
Properties are checked on every cycle:
- at most one opcode matches;
- a legal result carries the length byte of its window;
- an illegal or halt result has length 2 and all fields zero;
- a stalled result holds its outputs stable.

The byte-to-field mapping of each opcode can only be shown by the bench scenarios. So can result ordering under back-pressure and gaps, and the rejection of near-miss lengths and unlisted opcodes. The bench compares those scenarios against its own model.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int BYTE_W    = 8;
  localparam int WIN_BYTES = 9;
  localparam int WIN_W     = WIN_BYTES * BYTE_W;
  localparam int LEN_W     = 4;
  localparam int IMM_W     = 32;
  localparam int ADDR_W    = 16;
  localparam int NUM_OPS   = 11;
  localparam int ILL_LEN   = 2;

  typedef enum logic [3:0] {
    CLS_ILLEGAL = 4'd0,
    CLS_CONST   = 4'd1,
    CLS_ADD     = 4'd2,
    CLS_SUB     = 4'd3,
    CLS_MUL     = 4'd4,
    CLS_LOAD    = 4'd5,
    CLS_STORE   = 4'd6,
    CLS_BRANCH  = 4'd7,
    CLS_JUMP    = 4'd8,
    CLS_RETURN  = 4'd9,
    CLS_PHI     = 4'd10,
    CLS_HALT    = 4'd11
  } op_class_e;

  typedef struct packed {
    logic                illegal;
    op_class_e           cls;
    logic [LEN_W-1:0]    len;
    logic [BYTE_W-1:0]   dest;
    logic [BYTE_W-1:0]   src_a;
    logic [BYTE_W-1:0]   src_b;
    logic [IMM_W-1:0]    imm;
    logic [ADDR_W-1:0]   tgt_t;
    logic [ADDR_W-1:0]   tgt_f;
    logic [BYTE_W-1:0]   tag_t;
    logic [BYTE_W-1:0]   tag_f;
  } dec_out_t;

  // Entry i of the opcode table; entry i decodes to class i+1.
  function automatic logic [BYTE_W-1:0] op_code(input int i);
    case (i)
      0:  return 8'h01;
      1:  return 8'h02;
      2:  return 8'h03;
      3:  return 8'h04;
      4:  return 8'h05;
      5:  return 8'h06;
      6:  return 8'h07;
      7:  return 8'h08;
      8:  return 8'h09;
      9:  return 8'h0A;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] op_len(input int i);
    case (i)
      0:  return 4'd7;
      1, 2, 3: return 4'd5;
      4, 5: return 4'd4;
      6:  return 4'd9;
      7:  return 4'd5;
      8:  return 4'd3;
      9:  return 4'd7;
      default: return 4'd2;
    endcase
  endfunction

  function automatic op_class_e op_cls(input int i);
    return op_class_e'(4'(i + 1));
  endfunction
endpackage

// File: rtl/bcd_len_check.sv
module bcd_len_check
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0]  opc,
  input  logic [BYTE_W-1:0]  len_byte,
  output op_class_e          cls,
  output logic [LEN_W-1:0]   len,
  output logic               illegal,
  output logic [NUM_OPS-1:0] hit
);
  logic [NUM_OPS-1:0] len_ok;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    assign hit[i]    = (opc == op_code(i));
    assign len_ok[i] = hit[i] && (len_byte == BYTE_W'(op_len(i)));
  end

  always_comb begin
    cls = CLS_ILLEGAL;
    len = LEN_W'(ILL_LEN);
    for (int i = 0; i < NUM_OPS; i++) begin
      if (len_ok[i]) begin
        cls = op_cls(i);
        len = op_len(i);
      end
    end
    illegal = ~|len_ok;
  end
endmodule

// File: rtl/bcd_field_extract.sv
module bcd_field_extract
  import bcd_pkg::*;
(
  input  logic [WIN_W-1:0]  window,
  input  op_class_e         cls,
  output logic [BYTE_W-1:0] dest,
  output logic [BYTE_W-1:0] src_a,
  output logic [BYTE_W-1:0] src_b,
  output logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] tgt_t,
  output logic [ADDR_W-1:0] tgt_f,
  output logic [BYTE_W-1:0] tag_t,
  output logic [BYTE_W-1:0] tag_f
);
  logic [BYTE_W-1:0] b [WIN_BYTES];

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_byte
    assign b[k] = window[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    dest  = '0;
    src_a = '0;
    src_b = '0;
    imm   = '0;
    tgt_t = '0;
    tgt_f = '0;
    tag_t = '0;
    tag_f = '0;
    unique case (cls)
      CLS_CONST: begin
        dest = b[2];
        imm  = {b[6], b[5], b[4], b[3]};
      end
      CLS_ADD, CLS_SUB, CLS_MUL: begin
        dest  = b[2];
        src_a = b[3];
        src_b = b[4];
      end
      CLS_LOAD: begin
        dest  = b[2];
        src_a = b[3];
      end
      CLS_STORE: begin
        src_a = b[2];
        src_b = b[3];
      end
      CLS_BRANCH: begin
        src_a = b[2];
        tgt_t = {b[4], b[3]};
        tgt_f = {b[6], b[5]};
        tag_t = b[7];
        tag_f = b[8];
      end
      CLS_JUMP: begin
        tgt_t = {b[3], b[2]};
        tag_t = b[4];
      end
      CLS_RETURN: src_a = b[2];
      CLS_PHI: begin
        dest  = b[2];
        src_a = b[3];
        src_b = b[4];
        tag_t = b[5];
        tag_f = b[6];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (REG_OUT) begin : g_reg
    logic         full;
    logic [W-1:0] held;

    assign in_ready  = !full || out_ready;
    assign out_valid = full;
    assign out_data  = held;

    always_ff @(posedge clk) begin
      if (!rst_n) full <= 1'b0;
      else if (in_ready) full <= in_valid;
    end

    always_ff @(posedge clk) begin
      if (in_valid && in_ready) held <= in_data;
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  end else begin : g_wire
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/bcd_decoder.sv
module bcd_decoder
  import bcd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIN_W-1:0]  in_window,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_class,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_illegal,
  output logic [BYTE_W-1:0] out_dest,
  output logic [BYTE_W-1:0] out_src_a,
  output logic [BYTE_W-1:0] out_src_b,
  output logic [IMM_W-1:0]  out_imm,
  output logic [ADDR_W-1:0] out_tgt_t,
  output logic [ADDR_W-1:0] out_tgt_f,
  output logic [BYTE_W-1:0] out_tag_t,
  output logic [BYTE_W-1:0] out_tag_f
);
  localparam int PAY_W = $bits(dec_out_t);

  dec_out_t           d_dec;
  dec_out_t           d_out;
  logic [NUM_OPS-1:0] op_hit;

  bcd_len_check u_len (
    .opc      (in_window[0 +: BYTE_W]),
    .len_byte (in_window[BYTE_W +: BYTE_W]),
    .cls      (d_dec.cls),
    .len      (d_dec.len),
    .illegal  (d_dec.illegal),
    .hit      (op_hit)
  );

  bcd_field_extract u_fields (
    .window (in_window),
    .cls    (d_dec.cls),
    .dest   (d_dec.dest),
    .src_a  (d_dec.src_a),
    .src_b  (d_dec.src_b),
    .imm    (d_dec.imm),
    .tgt_t  (d_dec.tgt_t),
    .tgt_f  (d_dec.tgt_f),
    .tag_t  (d_dec.tag_t),
    .tag_f  (d_dec.tag_f)
  );

  logic [PAY_W-1:0] pay_out;

  bcd_out_stage #(.W(PAY_W), .REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (d_dec),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign d_out       = dec_out_t'(pay_out);
  assign out_class   = d_out.cls;
  assign out_len     = d_out.len;
  assign out_illegal = d_out.illegal;
  assign out_dest    = d_out.dest;
  assign out_src_a   = d_out.src_a;
  assign out_src_b   = d_out.src_b;
  assign out_imm     = d_out.imm;
  assign out_tgt_t   = d_out.tgt_t;
  assign out_tgt_f   = d_out.tgt_f;
  assign out_tag_t   = d_out.tag_t;
  assign out_tag_f   = d_out.tag_f;

  assert_one_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0(op_hit));

  assert_len_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !d_dec.illegal) |-> (BYTE_W'(d_dec.len) == in_window[BYTE_W +: BYTE_W]));

  assert_illegal_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_len == LEN_W'(ILL_LEN) && out_class == CLS_ILLEGAL
      && out_dest == '0 && out_src_a == '0 && out_src_b == '0 && out_imm == '0
      && out_tgt_t == '0 && out_tgt_f == '0 && out_tag_t == '0 && out_tag_f == '0));

  assert_halt_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == CLS_HALT) |-> (out_len == LEN_W'(ILL_LEN) && !out_illegal
      && out_dest == '0 && out_src_a == '0 && out_src_b == '0 && out_imm == '0
      && out_tgt_t == '0 && out_tgt_f == '0 && out_tag_t == '0 && out_tag_f == '0));
endmodule

// File: tb/bcd_decoder_bench.sv
`timescale 1ns/1ps
module bcd_decoder_bench;
  localparam int NDIR  = 18;
  localparam int NRAND = 500;
  localparam int RW    = 113;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [71:0] in_window = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [3:0]  out_class;
  logic [3:0]  out_len;
  logic        out_illegal;
  logic [7:0]  out_dest, out_src_a, out_src_b, out_tag_t, out_tag_f;
  logic [31:0] out_imm;
  logic [15:0] out_tgt_t, out_tgt_f;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bcd_decoder u_bcd_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_window(in_window), .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_len(out_len), .out_illegal(out_illegal),
    .out_dest(out_dest), .out_src_a(out_src_a), .out_src_b(out_src_b),
    .out_imm(out_imm), .out_tgt_t(out_tgt_t), .out_tgt_f(out_tgt_f),
    .out_tag_t(out_tag_t), .out_tag_f(out_tag_f)
  );

  function automatic logic [71:0] w9(input logic [7:0] b0, b1, b2, b3, b4,
                                     b5, b6, b7, b8);
    return {b8, b7, b6, b5, b4, b3, b2, b1, b0};
  endfunction

  // Behavioural model: {illegal, class, len, dest, a, b, imm, tt, tf, gt, gf}
  function automatic logic [RW-1:0] model(input logic [71:0] w);
    logic [7:0] b [9];
    logic ill = 1'b1;
    logic [3:0] c = 4'd0, l = 4'd2;
    logic [7:0] d = 0, sa = 0, sb = 0, gt = 0, gf = 0;
    logic [31:0] im = 0;
    logic [15:0] tt = 0, tf = 0;
    for (int k = 0; k < 9; k++) b[k] = w[k*8 +: 8];
    case (b[0])
      8'h01: if (b[1] == 8'd7) begin c = 1; d = b[2]; im = {b[6], b[5], b[4], b[3]}; end
      8'h02, 8'h03, 8'h04:
        if (b[1] == 8'd5) begin c = 4'(b[0]); d = b[2]; sa = b[3]; sb = b[4]; end
      8'h05: if (b[1] == 8'd4) begin c = 5; d = b[2]; sa = b[3]; end
      8'h06: if (b[1] == 8'd4) begin c = 6; sa = b[2]; sb = b[3]; end
      8'h07: if (b[1] == 8'd9) begin
        c = 7; sa = b[2]; tt = {b[4], b[3]}; tf = {b[6], b[5]}; gt = b[7]; gf = b[8];
      end
      8'h08: if (b[1] == 8'd5) begin c = 8; tt = {b[3], b[2]}; gt = b[4]; end
      8'h09: if (b[1] == 8'd3) begin c = 9; sa = b[2]; end
      8'h0A: if (b[1] == 8'd7) begin
        c = 10; d = b[2]; sa = b[3]; sb = b[4]; gt = b[5]; gf = b[6];
      end
      8'hFF: if (b[1] == 8'd2) c = 11;
      default: ;
    endcase
    if (c != 0) begin ill = 1'b0; l = b[1][3:0]; end
    return {ill, c, l, d, sa, sb, im, tt, tf, gt, gf};
  endfunction

  function automatic string req_of(input logic [RW-1:0] e);
    case (e[111:108])
      4'd0:  return "R2";
      4'd1:  return "R1 R3 R9";
      4'd2, 4'd3, 4'd4: return "R1 R4";
      4'd5, 4'd6: return "R1 R5 R9";
      4'd7:  return "R1 R6";
      4'd8, 4'd9: return "R1 R7 R9";
      4'd10: return "R1 R8 R9";
      default: return "R1 R9";
    endcase
  endfunction

  function automatic logic [31:0] rng(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13;
    t ^= t >> 17;
    t ^= t << 5;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [71:0] dir [NDIR];
  logic [RW-1:0] expq [$];
  logic [31:0] seed = 32'h1234_5678;
  logic [7:0] ops  [11] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'hFF};
  logic [7:0] lens [11] = '{8'd7, 8'd5, 8'd5, 8'd5, 8'd4, 8'd4, 8'd9, 8'd5, 8'd3, 8'd7, 8'd2};

  function automatic logic [71:0] rand_win(input logic [31:0] r1, input logic [31:0] r2,
                                           input logic [31:0] r3);
    logic [71:0] w = {r3[7:0], r2, r1};
    int i = int'(r3[15:8]) % 11;
    w[7:0] = ops[i];
    w[15:8] = lens[i];
    if (r3[18:16] == 3'd0) w[15:8] = lens[i] + 8'd1;
    else if (r3[18:16] == 3'd1) w[7:0] = r3[31:24];
    return w;
  endfunction

  initial begin
    dir[0]  = w9(8'h01, 8'd7, 8'h11, 8'h78, 8'h56, 8'h34, 8'h12, 8'hAA, 8'hBB);
    dir[1]  = w9(8'h02, 8'd5, 8'h21, 8'h22, 8'h23, 8'hEE, 8'hEE, 8'hEE, 8'hEE);
    dir[2]  = w9(8'h03, 8'd5, 8'h31, 8'h32, 8'h33, 8'h99, 8'h99, 8'h99, 8'h99);
    dir[3]  = w9(8'h04, 8'd5, 8'hFE, 8'h00, 8'h7F, 8'h01, 8'h02, 8'h03, 8'h04);
    dir[4]  = w9(8'h05, 8'd4, 8'h41, 8'h42, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55);
    dir[5]  = w9(8'h06, 8'd4, 8'h51, 8'h52, 8'h66, 8'h66, 8'h66, 8'h66, 8'h66);
    dir[6]  = w9(8'h07, 8'd9, 8'h61, 8'h34, 8'h12, 8'hCD, 8'hAB, 8'h05, 8'h06);
    dir[7]  = w9(8'h08, 8'd5, 8'h00, 8'h80, 8'h07, 8'h77, 8'h77, 8'h77, 8'h77);
    dir[8]  = w9(8'h09, 8'd3, 8'h71, 8'h88, 8'h88, 8'h88, 8'h88, 8'h88, 8'h88);
    dir[9]  = w9(8'h0A, 8'd7, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86, 8'h87);
    dir[10] = w9(8'hFF, 8'd2, 8'h91, 8'h92, 8'h93, 8'h94, 8'h95, 8'h96, 8'h97);
    dir[11] = w9(8'h00, 8'd2, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07);
    dir[12] = w9(8'h0B, 8'd5, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07);
    dir[13] = w9(8'h02, 8'd4, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07);
    dir[14] = w9(8'h07, 8'd8, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07);
    dir[15] = w9(8'hFF, 8'd3, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07);
    dir[16] = w9(8'h01, 8'd7, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    dir[17] = w9(8'h05, 8'h14, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07);
  end

  initial begin
    int idx = 0;
    bit acc = 1'b0;
    logic [RW-1:0] act, exp;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11",
          RW'({out_valid, in_ready}), RW'(2'b01));
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      if (!in_valid || acc) begin
        if (idx < NDIR + NRAND && (cyc % 7) != 2) begin
          if (idx < NDIR) in_window = dir[idx];
          else begin
            logic [31:0] r1, r2, r3;
            r1 = rng(seed); r2 = rng(r1); r3 = rng(r2); seed = r3;
            in_window = rand_win(r1, r2, r3);
          end
          in_valid = 1'b1;
          idx++;
        end else in_valid = 1'b0;
      end
      out_ready = ((cyc % 5) != 3) && ((cyc % 11) != 4);
      #1;
      check(out_valid == (expq.size() != 0), "R10", RW'(out_valid), RW'(expq.size() != 0));
      check(in_ready == (!out_valid || out_ready), "R10", RW'(in_ready),
            RW'(!out_valid || out_ready));
      if (out_valid && out_ready && expq.size() != 0) begin
        exp = expq.pop_front();
        act = {out_illegal, out_class, out_len, out_dest, out_src_a, out_src_b,
               out_imm, out_tgt_t, out_tgt_f, out_tag_t, out_tag_f};
        check(act == exp, req_of(exp), act, exp);
      end
      acc = in_valid && in_ready;
      if (acc) expq.push_back(model(in_window));
      if (idx >= NDIR + NRAND && !in_valid && expq.size() == 0) break;
    end
    check(expq.size() == 0, "R10", RW'(expq.size()), RW'(0));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule